// File: doc/BRIEF.md
# Input Pulse Width Measurement Timer

This block is one timer channel that measures how long an input signal stays at a chosen level. Software configures the measured level and the count clock, then fires a one-cycle arm strobe. The channel becomes active but does not count yet. It waits for the edge on the synchronized input that opens the level. That edge clears the counter, and the counter then advances on every tick of the selected clock enable. The edge that closes the level copies the counter into the result register, rewrites the overflow flag for this measurement and raises a one-cycle interrupt. The counter then freezes until the next opening edge, so measurements repeat without re-arming.

A halt strobe deactivates the channel and leaves the counter and the overflow flag unchanged. The live counter can be read at any time. The result register can be written by software at any time. The configuration is accepted only while the channel is inactive. Two clock-enable inputs stand in for an external prescaler.

Top module: `pulse_width_timer`

## Requirements
- R1: After synchronous reset the counter, the result register, the overflow flag, the interrupt and the active status are all 0.
- R2: An arm strobe sets the active status on the next cycle. The counter does not change until an opening edge is seen on the input.
- R3: An opening edge clears the counter to 0. From the next cycle the counter adds 1 per selected tick, so a level held for N clock cycles with the tick always high produces a result of N-1.
- R4: A closing edge copies the counter into the result register and drives the interrupt high for exactly one cycle.
- R5: At each capture the overflow flag is set to 1 if the counter wrapped from all-ones to 0 during that measurement, and is set to 0 otherwise. Counting continues after a wrap.
- R6: After a capture the counter holds its value until the next opening edge. A following pulse is measured without a new arm strobe.
- R7: A halt strobe clears the active status on the next cycle. The counter and the overflow flag keep their values, and a later closing edge raises no interrupt. Halt takes priority over arm and over capture.
- R8: Level select 0 measures high time (a rising edge opens, a falling edge closes). Level select 1 measures low time (a falling edge opens, a rising edge closes).
- R9: Clock select 0 counts on tick_a and clock select 1 counts on tick_b.
- R10: A configuration write while the channel is active is ignored. A write to the result register is accepted at any time, and a capture in the same cycle wins over it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | Prescaled count enable, choice 0 |
| tick_b | input | 1 | Prescaled count enable, choice 1 |
| cfg_we | input | 1 | Configuration write strobe (accepted only when inactive) |
| cfg_level | input | 1 | Level select: 0 high time, 1 low time |
| cfg_clk_sel | input | 1 | Count enable select: 0 tick_a, 1 tick_b |
| arm | input | 1 | One-cycle start trigger |
| halt | input | 1 | One-cycle stop trigger |
| res_we | input | 1 | Result register write strobe |
| res_wdata | input | W | Result register write data |
| pin_in | input | 1 | Asynchronous measured input |
| active | output | 1 | Channel enabled |
| count_q | output | W | Live counter |
| result_q | output | W | Captured width |
| ovf_q | output | 1 | Overflow during the last captured measurement |
| irq | output | 1 | One-cycle capture interrupt |

## Verification
The checker watches every cycle for these properties: the counter only ever holds, steps by one or returns to zero; the interrupt never lasts two cycles and only appears while active; each capture equals the counter value of the cycle before; and an inactive channel keeps its counter and flag. The bench scenarios cover the behaviour that needs a whole stimulus history. This covers the exact width for a known pulse, the overflow flag being set and then cleared over a 65 536-tick wrap, the swapped edges under low-level select, the clock-enable choice, and configuration writes that are refused while active.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_MEAS = 2'd2
    } pwt_state_e;

    typedef struct packed {
        logic level_low;
        logic clk_sel;
    } pwt_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } pwt_edges_t;

    localparam pwt_cfg_t CFG_RESET = '{level_low: 1'b0, clk_sel: 1'b0};

    function automatic logic pick_tick(input pwt_cfg_t cfg, input logic ta, input logic tb);
        return cfg.clk_sel ? tb : ta;
    endfunction

    function automatic logic open_edge(input pwt_cfg_t cfg, input pwt_edges_t e);
        return cfg.level_low ? e.fall : e.rise;
    endfunction

    function automatic logic close_edge(input pwt_cfg_t cfg, input pwt_edges_t e);
        return cfg.level_low ? e.rise : e.fall;
    endfunction

endpackage

// File: rtl/pwt_sync_edge.sv
module pwt_sync_edge
    import pwt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       d_in,
    output pwt_edges_t edges
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    always_comb begin
        edges.rise = chain[STAGES-1] & ~prev;
        edges.fall = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_o  <= '0;
            wrap_o <= 1'b0;
        end else if (inc) begin
            cnt_o <= cnt_o + 1'b1;
            if (cnt_o == ALL_ONES) wrap_o <= 1'b1;
        end
    end
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
    import pwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       halt,
    input  logic       open_ev,
    input  logic       close_ev,
    output pwt_state_e state_o,
    output logic       clr_o,
    output logic       cap_o,
    output logic       irq_o
);
    pwt_state_e nxt;

    always_comb begin
        nxt   = state_o;
        clr_o = 1'b0;
        cap_o = 1'b0;
        if (halt) begin
            nxt = ST_OFF;
        end else begin
            unique case (state_o)
                ST_OFF:  if (arm) nxt = ST_WAIT;
                ST_WAIT: if (open_ev) begin
                    nxt   = ST_MEAS;
                    clr_o = 1'b1;
                end
                ST_MEAS: if (close_ev) begin
                    nxt   = ST_WAIT;
                    cap_o = 1'b1;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o <= ST_OFF;
            irq_o   <= 1'b0;
        end else begin
            state_o <= nxt;
            irq_o   <= cap_o;
        end
    end
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer
    import pwt_pkg::*;
#(
    parameter int W         = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_a,
    input  logic         tick_b,
    input  logic         cfg_we,
    input  logic         cfg_level,
    input  logic         cfg_clk_sel,
    input  logic         arm,
    input  logic         halt,
    input  logic         res_we,
    input  logic [W-1:0] res_wdata,
    input  logic         pin_in,
    output logic         active,
    output logic [W-1:0] count_q,
    output logic [W-1:0] result_q,
    output logic         ovf_q,
    output logic         irq
);
    pwt_cfg_t   cfg_r;
    pwt_edges_t edges;
    pwt_state_e state;
    logic       clr, cap, inc, wrap, tick_sel;

    always_ff @(posedge clk) begin
        if (rst)                    cfg_r <= CFG_RESET;
        else if (cfg_we && !active) cfg_r <= '{level_low: cfg_level, clk_sel: cfg_clk_sel};
    end

    pwt_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pin_in),
        .edges (edges)
    );

    pwt_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .halt     (halt),
        .open_ev  (open_edge(cfg_r, edges)),
        .close_ev (close_edge(cfg_r, edges)),
        .state_o  (state),
        .clr_o    (clr),
        .cap_o    (cap),
        .irq_o    (irq)
    );

    assign tick_sel = pick_tick(cfg_r, tick_a, tick_b);
    assign inc      = (state == ST_MEAS) && tick_sel && !cap && !halt;
    assign active   = (state != ST_OFF);

    pwt_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .inc    (inc),
        .cnt_o  (count_q),
        .wrap_o (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            ovf_q    <= 1'b0;
        end else if (cap) begin
            result_q <= count_q;
            ovf_q    <= wrap;
        end else if (res_we) begin
            result_q <= res_wdata;
        end
    end
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         arm,
    input logic         active,
    input logic [W-1:0] count_q,
    input logic [W-1:0] result_q,
    input logic         ovf_q,
    input logic         irq
);
    // R4: interrupt is a single-cycle pulse
    p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7: no interrupt unless the channel is active
    p_irq_active_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> active);

    // R4: captured value is the counter of the previous cycle
    p_capture_value_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> result_q == $past(count_q));

    // R3: counter holds, steps by one, or returns to zero
    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(count_q) |-> (count_q == '0 || count_q == $past(count_q) + 1'b1));

    // R7: inactive channel keeps counter and flag
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!active && !arm) |=> ($stable(count_q) && $stable(ovf_q)));
endmodule

bind pulse_width_timer pwt_checker #(.W(W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .arm      (arm),
    .active   (active),
    .count_q  (count_q),
    .result_q (result_q),
    .ovf_q    (ovf_q),
    .irq      (irq)
);

// File: tb/test_pulse_width_timer.sv
module test_pulse_width_timer;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_a = 1'b1, tick_b = 1'b0;
    logic         cfg_we = 1'b0, cfg_level = 1'b0, cfg_clk_sel = 1'b0;
    logic         arm = 1'b0, halt = 1'b0;
    logic         res_we = 1'b0;
    logic [W-1:0] res_wdata = '0;
    logic         pin_in = 1'b0;
    logic         active, ovf_q, irq;
    logic [W-1:0] count_q, result_q;

    int checks = 0;
    int errors = 0;
    int irq_hi = 0;

    always #10 clk = ~clk;

    pulse_width_timer #(.W(W)) i_pulse_width_timer (
        .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b),
        .cfg_we(cfg_we), .cfg_level(cfg_level), .cfg_clk_sel(cfg_clk_sel),
        .arm(arm), .halt(halt), .res_we(res_we), .res_wdata(res_wdata),
        .pin_in(pin_in), .active(active), .count_q(count_q),
        .result_q(result_q), .ovf_q(ovf_q), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_hi++;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe_arm();
        arm = 1'b1; wait_cyc(1); arm = 1'b0;
    endtask

    task automatic strobe_halt();
        halt = 1'b1; wait_cyc(1); halt = 1'b0;
    endtask

    task automatic write_cfg(input logic lvl, input logic sel);
        cfg_level = lvl; cfg_clk_sel = sel; cfg_we = 1'b1;
        wait_cyc(1); cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic lvl, input int n);
        pin_in = lvl; wait_cyc(n); pin_in = ~lvl; wait_cyc(8);
    endtask

    task automatic t_reset();
        chk("R1 count", count_q, 0);
        chk("R1 result", result_q, 0);
        chk("R1 ovf", ovf_q, 0);
        chk("R1 irq", irq, 0);
        chk("R1 active", active, 0);
    endtask

    task automatic t_arm_wait();
        strobe_arm();
        chk("R2 active after arm", active, 1);
        wait_cyc(10);
        chk("R2 no count before open edge", count_q, 0);
        chk("R2 no irq", irq_hi, 0);
    endtask

    task automatic t_basic();
        int i0;
        i0 = irq_hi;
        pulse(1'b1, 37);
        chk("R3 width result", result_q, 36);
        chk("R4 one irq cycle", irq_hi - i0, 1);
        chk("R5 no overflow", ovf_q, 0);
        wait_cyc(20);
        chk("R6 counter frozen", count_q, 36);
        pulse(1'b1, 5);
        chk("R6 second pulse without arm", result_q, 4);
        chk("R4 irq per capture", irq_hi - i0, 2);
    endtask

    task automatic t_clk_sel();
        strobe_halt();
        write_cfg(1'b0, 1'b1);
        strobe_arm();
        pulse(1'b1, 30);
        chk("R9 tick_b idle gives zero", result_q, 0);
        strobe_halt();
        write_cfg(1'b0, 1'b0);
        strobe_arm();
        pulse(1'b1, 14);
        chk("R9 tick_a selected", result_q, 13);
    endtask

    task automatic t_overflow();
        pulse(1'b1, 65542);
        chk("R5 wrapped result", result_q, 5);
        chk("R5 overflow set", ovf_q, 1);
    endtask

    task automatic t_halt();
        logic [W-1:0] c1;
        int i0;
        i0 = irq_hi;
        pin_in = 1'b1;
        wait_cyc(20);
        strobe_halt();
        chk("R7 inactive after halt", active, 0);
        c1 = count_q;
        chk("R7 counter was running", (c1 > 0) ? 1 : 0, 1);
        wait_cyc(10);
        pin_in = 1'b0;
        wait_cyc(10);
        chk("R7 counter held", count_q, c1);
        chk("R7 overflow held", ovf_q, 1);
        chk("R7 no irq after halt", irq_hi - i0, 0);
        strobe_arm();
        pulse(1'b1, 10);
        chk("R5 overflow cleared", ovf_q, 0);
        chk("R5 short result", result_q, 9);
    endtask

    task automatic t_cfg_lock();
        write_cfg(1'b1, 1'b1);
        res_wdata = 16'h1234; res_we = 1'b1;
        wait_cyc(1); res_we = 1'b0;
        chk("R10 result write accepted", result_q, 16'h1234);
        pulse(1'b1, 12);
        chk("R10 cfg write ignored while active", result_q, 11);
    endtask

    task automatic t_low_level();
        strobe_halt();
        write_cfg(1'b1, 1'b0);
        pin_in = 1'b1;
        wait_cyc(6);
        strobe_arm();
        pulse(1'b0, 25);
        chk("R8 low-level width", result_q, 24);
        pulse(1'b1, 40);
        chk("R8 high level not measured", result_q, 24);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        t_reset();
        t_arm_wait();
        t_basic();
        t_clk_sel();
        t_overflow();
        t_halt();
        t_cfg_lock();
        t_low_level();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule